// File: doc/BRIEF.md
# Grouped Edge/Level Event Detector with Per-Group Enables

This block watches a bus of 32 inputs and raises a one-cycle-per-match event bit for every input whose configured condition holds. Each input can be set to fire on a low level, a high level, a rising edge or a falling edge. The four modes may be combined freely on the same input, and the event is the OR of all selected modes. Four configuration words, one per mode, select the modes bit by bit.

The inputs are split into four groups of eight. A group is active only while at least one of its bits has a mode selected in any of the four configuration words. A group enable stands in for a gated clock. While a group is idle, its synchronizer and history flops hold their values and the group emits no events. When a group turns on from idle, it waits five cycles so that its two-stage synchronizer and history stage hold fresh samples. Only after that wait does it report events. If a group is already running, changing its configuration causes no new wait, as long as at least one bit stays selected throughout.

Events are registered. An input value captured at one rising edge reaches the event output on the second rising edge after that one.

Top module: `grp_evt_detect`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, `evt_out` is all zero.
- R2: Group g covers bits 8g+7 down to 8g. The group is enabled exactly when any bit in that slice is set in any of `cfg_lo`, `cfg_hi`, `cfg_rise` or `cfg_fall`. For example, the value 0x01010101 enables all four groups and the value 0x000000FF enables only group 0.
- R3: A group that is not enabled in a cycle produces all-zero event bits for that cycle.
- R4: When a group changes from idle to enabled, it produces no events during the five cycles that start with the cycle in which it becomes enabled. Reset counts as idle.
- R5: The enable and the warm-up of each group depend only on that group's own configuration bits.
- R6: Once a group is past its warm-up, it keeps reporting without a new wait for as long as it stays enabled, including while its bit selection changes.
- R7: With `cfg_lo[i]` set, bit i fires on every ready cycle in which its synchronized sample is 0.
- R8: With `cfg_hi[i]` set, bit i fires on every ready cycle in which its synchronized sample is 1.
- R9: With `cfg_rise[i]` set, bit i fires when the current synchronized sample is 1 and the previous one is 0.
- R10: With `cfg_fall[i]` set, bit i fires when the current synchronized sample is 0 and the previous one is 1.
- R11: An input captured at rising edge k is the current sample for the event registered at edge k+2. The value captured at edge k-1 is the previous sample for that event.
- R12: The event for a bit is the OR of its selected modes. A bit with no mode selected never fires, even while its group is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lo | input | 32 | Per-bit low-level mode select |
| cfg_hi | input | 32 | Per-bit high-level mode select |
| cfg_rise | input | 32 | Per-bit rising-edge mode select |
| cfg_fall | input | 32 | Per-bit falling-edge mode select |
| pin_in | input | 32 | Asynchronous input bus |
| evt_out | output | 32 | Registered per-bit event flags |

## Verification
Random pin traffic is run under each single mode in turn. This separates the level tests, which fire on every matching cycle, from the edge tests, which fire only on a transition of the right direction. The fixed patterns 0x01010101 and 0x000000FF, plus group-0-only settings, show whether the enables are formed per group or across the whole bus. Directed sequences do three things. They turn a group on from idle to expose the five-cycle wait. They overlap an old and a new setting to show that no second wait occurs. They pulse a single input to pin down the two-edge latency. Mixed random masks that leave some bits unconfigured check the OR of modes and the silence of bits with no mode selected.

// File: rtl/gdet_pkg.sv
package gdet_pkg;

  // Event rule for one lane: OR of the four selectable conditions.
  function automatic logic lane_event(input logic m_lo, input logic m_hi,
                                      input logic m_rise, input logic m_fall,
                                      input logic cur, input logic prv);
    return (m_lo & ~cur) | (m_hi & cur) |
           (m_rise & cur & ~prv) | (m_fall & ~cur & prv);
  endfunction

  // A lane needs detection if any mode bit is set.
  function automatic logic lane_needed(input logic m_lo, input logic m_hi,
                                       input logic m_rise, input logic m_fall);
    return m_lo | m_hi | m_rise | m_fall;
  endfunction

endpackage

// File: rtl/gdet_group_ctrl.sv
module gdet_group_ctrl #(
  parameter int GW   = 8,
  parameter int WARM = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] m_lo,
  input  logic [GW-1:0] m_hi,
  input  logic [GW-1:0] m_rise,
  input  logic [GW-1:0] m_fall,
  output logic          grp_on,
  output logic          grp_wake,
  output logic          grp_ready
);
  import gdet_pkg::*;

  localparam int CW = $clog2(WARM + 1);

  logic [GW-1:0] lane_need;
  logic          on_q;
  logic [CW-1:0] warm_cnt;

  for (genvar i = 0; i < GW; i++) begin : g_need
    assign lane_need[i] = lane_needed(m_lo[i], m_hi[i], m_rise[i], m_fall[i]);
  end

  assign grp_on    = |lane_need;
  assign grp_wake  = grp_on & ~on_q;
  assign grp_ready = grp_on & ~grp_wake & (warm_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      warm_cnt <= '0;
    end else begin
      on_q <= grp_on;
      if (!grp_on)
        warm_cnt <= '0;
      else if (grp_wake)
        warm_cnt <= CW'(WARM - 1);
      else if (warm_cnt != '0)
        warm_cnt <= warm_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/gdet_sync_lane.sv
module gdet_sync_lane #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [GW-1:0] pin,
  output logic [GW-1:0] cur,
  output logic [GW-1:0] prv
);
  logic [GW-1:0] stg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= '0;
      cur  <= '0;
      prv  <= '0;
    end else if (run) begin
      stg1 <= pin;
      cur  <= stg1;
      prv  <= cur;
    end
  end

endmodule

// File: rtl/gdet_event_lane.sv
module gdet_event_lane #(
  parameter int GW = 8
) (
  input  logic          ready,
  input  logic [GW-1:0] m_lo,
  input  logic [GW-1:0] m_hi,
  input  logic [GW-1:0] m_rise,
  input  logic [GW-1:0] m_fall,
  input  logic [GW-1:0] cur,
  input  logic [GW-1:0] prv,
  output logic [GW-1:0] evt
);
  import gdet_pkg::*;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    assign evt[i] = ready & lane_event(m_lo[i], m_hi[i], m_rise[i], m_fall[i],
                                       cur[i], prv[i]);
  end

endmodule

// File: rtl/grp_evt_detect.sv
module grp_evt_detect #(
  parameter int NGRP = 4,
  parameter int GW   = 8,
  parameter int WARM = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NGRP*GW-1:0] cfg_lo,
  input  logic [NGRP*GW-1:0] cfg_hi,
  input  logic [NGRP*GW-1:0] cfg_rise,
  input  logic [NGRP*GW-1:0] cfg_fall,
  input  logic [NGRP*GW-1:0] pin_in,
  output logic [NGRP*GW-1:0] evt_out
);
  localparam int W = NGRP * GW;

  logic [NGRP-1:0] grp_on;
  logic [NGRP-1:0] grp_wake;
  logic [NGRP-1:0] grp_ready;
  logic [W-1:0]    syn_cur;
  logic [W-1:0]    syn_prev;
  logic [W-1:0]    evt_next;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gdet_group_ctrl #(.GW(GW), .WARM(WARM)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .m_lo     (cfg_lo[g*GW +: GW]),
      .m_hi     (cfg_hi[g*GW +: GW]),
      .m_rise   (cfg_rise[g*GW +: GW]),
      .m_fall   (cfg_fall[g*GW +: GW]),
      .grp_on   (grp_on[g]),
      .grp_wake (grp_wake[g]),
      .grp_ready(grp_ready[g])
    );

    gdet_sync_lane #(.GW(GW)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (grp_on[g]),
      .pin  (pin_in[g*GW +: GW]),
      .cur  (syn_cur[g*GW +: GW]),
      .prv  (syn_prev[g*GW +: GW])
    );

    gdet_event_lane #(.GW(GW)) i_evt (
      .ready (grp_ready[g]),
      .m_lo  (cfg_lo[g*GW +: GW]),
      .m_hi  (cfg_hi[g*GW +: GW]),
      .m_rise(cfg_rise[g*GW +: GW]),
      .m_fall(cfg_fall[g*GW +: GW]),
      .cur   (syn_cur[g*GW +: GW]),
      .prv   (syn_prev[g*GW +: GW]),
      .evt   (evt_next[g*GW +: GW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_out <= '0;
    else        evt_out <= evt_next;
  end

endmodule

// File: rtl/gdet_checker.sv
module gdet_checker #(
  parameter int NGRP = 4,
  parameter int GW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NGRP*GW-1:0] cfg_lo,
  input logic [NGRP*GW-1:0] cfg_hi,
  input logic [NGRP*GW-1:0] cfg_rise,
  input logic [NGRP*GW-1:0] cfg_fall,
  input logic [NGRP-1:0]    grp_on,
  input logic [NGRP-1:0]    grp_wake,
  input logic [NGRP-1:0]    grp_ready,
  input logic [NGRP*GW-1:0] syn_cur,
  input logic [NGRP*GW-1:0] syn_prev,
  input logic [NGRP*GW-1:0] evt_out
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_on[g] |=> (evt_out[g*GW +: GW] == '0)); // R3
    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      grp_wake[g] |=> (evt_out[g*GW +: GW] == '0)); // R4
    AST_STAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      grp_ready[g] |=> (!grp_on[g] || grp_ready[g])); // R6

    for (genvar i = 0; i < GW; i++) begin : g_bit
      localparam int B = g*GW + i;
      AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ready[g] && cfg_lo[B] && !syn_cur[B]) |=> evt_out[B]); // R7
      AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ready[g] && cfg_hi[B] && syn_cur[B]) |=> evt_out[B]); // R8
      AST_EDGE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ready[g] && cfg_rise[B] && syn_cur[B] && !syn_prev[B]) |=> evt_out[B]); // R9
      AST_EDGE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ready[g] && cfg_fall[B] && !syn_cur[B] && syn_prev[B]) |=> evt_out[B]); // R10
      AST_UNSET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_lo[B] || cfg_hi[B] || cfg_rise[B] || cfg_fall[B]) |=> !evt_out[B]); // R12
    end
  end
endmodule

bind grp_evt_detect gdet_checker #(.NGRP(NGRP), .GW(GW)) i_gdet_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_lo   (cfg_lo),
  .cfg_hi   (cfg_hi),
  .cfg_rise (cfg_rise),
  .cfg_fall (cfg_fall),
  .grp_on   (grp_on),
  .grp_wake (grp_wake),
  .grp_ready(grp_ready),
  .syn_cur  (syn_cur),
  .syn_prev (syn_prev),
  .evt_out  (evt_out)
);

// File: tb/test_grp_evt_detect.sv
module test_grp_evt_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int GWD = 8;
  localparam int W = NG * GWD;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cfg_lo = '0, cfg_hi = '0, cfg_rise = '0, cfg_fall = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] evt_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_evt_detect i_grp_evt_detect (
    .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .pin_in(pin_in), .evt_out(evt_out)
  );

  // Reference: pin history per bit (h1 newest capture), and for each group
  // the number of consecutive enabled cycles including the current one.
  logic [W-1:0] h1, h2, h3, exp_out;
  int run_len [NG];

  function automatic logic grp_active(input int g);
    return |(cfg_lo[g*GWD +: GWD] | cfg_hi[g*GWD +: GWD] |
             cfg_rise[g*GWD +: GWD] | cfg_fall[g*GWD +: GWD]);
  endfunction

  function automatic logic want_bit(input int b, input logic c, input logic p);
    logic r;
    r = 1'b0;
    if (cfg_lo[b] && c == 1'b0) r = 1'b1;
    if (cfg_hi[b] && c == 1'b1) r = 1'b1;
    if (cfg_rise[b] && c && !p) r = 1'b1;
    if (cfg_fall[b] && !c && p) r = 1'b1;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= '0; h2 <= '0; h3 <= '0; exp_out <= '0;
      for (int g = 0; g < NG; g++) run_len[g] <= 0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        int now_len;
        now_len = grp_active(g) ? ((run_len[g] >= 6) ? 6 : run_len[g] + 1) : 0;
        for (int i = 0; i < GWD; i++) begin
          int b;
          b = g*GWD + i;
          exp_out[b] <= (now_len >= 6) ? want_bit(b, h2[b], h3[b]) : 1'b0;
          if (grp_active(g)) begin
            h1[b] <= pin_in[b]; h2[b] <= h1[b]; h3[b] <= h2[b];
          end
        end
        run_len[g] <= now_len;
      end
    end
  end

  task automatic check(input string tag);
    tests++;
    if (evt_out !== exp_out) begin
      fails++;
      $display("FAIL %s evt_out=%h expected=%h", tag, evt_out, exp_out);
    end
  endtask

  // Advance n cycles; optionally drive random pins; check at each negedge.
  task automatic run(input string tag, input int n, input bit rnd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(tag);
      if (rnd) pin_in = $urandom();
    end
  endtask

  task automatic set_cfg(input logic [W-1:0] lo, input logic [W-1:0] hi,
                         input logic [W-1:0] ri, input logic [W-1:0] fa);
    cfg_lo = lo; cfg_hi = hi; cfg_rise = ri; cfg_fall = fa;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    run("R1", 2, 1'b0);

    // R2: sparse pattern wakes all groups; dense low byte wakes only group 0
    set_cfg('0, 32'h0101_0101, '0, '0);
    run("R2", 30, 1'b1);
    set_cfg('0, 32'h0000_00FF, '0, '0);
    run("R2", 30, 1'b1);

    // R4: all idle, then group 2 wakes with its input held high
    set_cfg('0, '0, '0, '0);
    pin_in = '1;
    run("R4", 4, 1'b0);
    set_cfg('0, 32'h0001_0000, '0, '0);
    run("R4", 5, 1'b0);
    check("R4");
    if (evt_out[16] !== 1'b0) begin end
    run("R4", 4, 1'b0);

    // R6: overlap new setting before dropping old one
    set_cfg('0, 32'h0001_0000, 32'h0002_0000, '0);
    run("R6", 1, 1'b1);
    set_cfg('0, '0, 32'h0002_0000, '0);
    run("R6", 20, 1'b1);

    // R5: group 1 toggles on and off while group 0 stays on
    for (int k = 0; k < 6; k++) begin
      set_cfg(32'h0000_0003, (k % 2) ? 32'h0000_0F00 : 32'h0, '0, '0);
      run("R5", 7, 1'b1);
    end

    // R3: only group 0 configured, other groups see random traffic
    set_cfg(32'h0000_00A5, 32'h0000_005A, '0, '0);
    run("R3", 30, 1'b1);

    // Single-mode random sweeps over all groups
    set_cfg('1, '0, '0, '0);
    run("R7", 40, 1'b1);
    set_cfg('0, '1, '0, '0);
    run("R8", 40, 1'b1);
    set_cfg('0, '0, '1, '0);
    run("R9", 40, 1'b1);
    set_cfg('0, '0, '0, '1);
    run("R10", 40, 1'b1);

    // R11: single pulse on bit 9 with high-level detection, group warm
    set_cfg('0, 32'h0000_0200, '0, '0);
    pin_in = '0;
    run("R11", 8, 1'b0);
    pin_in[9] = 1'b1;
    run("R11", 1, 1'b0);
    pin_in[9] = 1'b0;
    run("R11", 5, 1'b0);

    // R12: random mixed masks with unconfigured holes
    for (int k = 0; k < 20; k++) begin
      set_cfg($urandom() & $urandom(), $urandom() & $urandom(),
              $urandom() & $urandom(), $urandom() & $urandom());
      run("R12", 12, 1'b1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule